// File: doc/BRIEF.md
# Programmable Interrupt Pin Generator

This block collects event strobes from two groups of sources, one for USB events and one for DMA events, and keeps a sticky status bit for every source. Each group has its own enable register. The enabled, pending bits of both groups are OR-ed together and gated by one global enable, and the result drives a single interrupt pin. Software clears status bits by writing ones to them.

The pin can be set to active-high or active-low. It also has two signalling modes. In level mode the pin stays asserted as long as any enabled bit is pending and the global enable is set. In pulse mode the pin gives one pulse of fixed width each time the enabled OR goes from 0 to 1 while the global enable is set. That width is at least 60 ns and is rounded up to whole clock cycles from the clock period parameter. In pulse mode, events that were already pending when the global enable was turned on give no pulse.

All register writes are single-cycle write strobes with data. Status, enables, configuration and the global enable can be read back on output ports.

Top module: `irq_pin_gen`

## Requirements
- R1: Every event strobe sets its status bit at the next clock edge, whatever the state of its own enable bit and of the global enable.
- R2: A status-clear write clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R3: If an event and a clear of the same bit happen in the same cycle, the bit stays set.
- R4: After reset, all status bits are 0, both enable registers are 0 and the global enable is 0. The configuration is active-low polarity in level mode, so the pin reads 1.
- R5: In level mode with the global enable set, the pin goes active one cycle after an enabled status bit of either group becomes visible as pending.
- R6: A pending bit whose enable is 0 never asserts the pin. While the global enable is 0 the pin stays inactive, one cycle after the global enable is read as 0. In level mode, setting the global enable while an enabled bit is pending asserts the pin one cycle after the write takes effect.
- R7: In level mode the pin stays active while an enabled bit is pending. It deasserts one cycle after the last enabled pending bit is cleared.
- R8: In pulse mode, a 0-to-1 change of the enabled OR, with the global enable set, gives exactly one active pulse of ceil(60000 ps / CLK_PS) cycles. This is 4 cycles at the default 16667 ps. After the pulse the pin stays inactive even if bits remain pending, and a new event on a bit that is already pending gives no new pulse.
- R9: In pulse mode, enabled bits that were already pending when the global enable is set give no pulse.
- R10: With the polarity bit set to 1, the pin is 1 when active and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_evt_i | input | USB_W | USB event strobes, one per source |
| dma_evt_i | input | DMA_W | DMA event strobes, one per source |
| usb_clr_we_i | input | 1 | Write strobe for the USB status clear |
| usb_clr_data_i | input | USB_W | USB bits to clear (1 = clear) |
| usb_en_we_i | input | 1 | Write strobe for the USB enable register |
| usb_en_data_i | input | USB_W | New USB enable value |
| dma_clr_we_i | input | 1 | Write strobe for the DMA status clear |
| dma_clr_data_i | input | DMA_W | DMA bits to clear (1 = clear) |
| dma_en_we_i | input | 1 | Write strobe for the DMA enable register |
| dma_en_data_i | input | DMA_W | New DMA enable value |
| cfg_we_i | input | 1 | Write strobe for the pin configuration |
| cfg_pol_high_i | input | 1 | 1 = active-high pin, 0 = active-low pin |
| cfg_pulse_mode_i | input | 1 | 1 = pulse mode, 0 = level mode |
| glb_we_i | input | 1 | Write strobe for the global enable |
| glb_en_i | input | 1 | New global enable value |
| irq_pin_o | output | 1 | Interrupt pin |
| usb_status_o | output | USB_W | USB status read-back |
| usb_enable_o | output | USB_W | USB enable read-back |
| dma_status_o | output | DMA_W | DMA status read-back |
| dma_enable_o | output | DMA_W | DMA enable read-back |
| cfg_pol_high_o | output | 1 | Polarity read-back |
| cfg_pulse_mode_o | output | 1 | Mode read-back |
| glb_en_o | output | 1 | Global enable read-back |

## Verification
Status and register read-back change one clock edge after the strobe that causes them. The pin is registered once more, so it follows an event two edges after the strobe and follows a clear, enable or global-enable write one edge after that write. The bench drives every strobe at a falling edge and samples at falling edges. For each scenario it first checks that the pin has not yet moved one edge early, then checks the expected value on the edge where the change is due. Pulses are measured by counting active samples over a window longer than the expected width, so a pulse that starts late, ends early or fires again shows up as a mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef struct packed {
        logic pol_high;
        logic pulse_mode;
    } irq_cfg_t;

    // Cycles needed to cover width_ps at a clock of clk_ps, never less than one.
    function automatic int unsigned pulse_cycles(input int unsigned width_ps,
                                                 input int unsigned clk_ps);
        int unsigned n;
        n = (width_ps + clk_ps - 1) / clk_ps;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_data_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] enable_o,
    output logic         pend_o
);

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] enable;
    } bank_t;

    bank_t        bank_d, bank_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        bank_d   = bank_q;
        clr_mask = clr_we_i ? clr_data_i : '0;
        // A new event wins over a clear of the same bit.
        bank_d.status = (bank_q.status & ~clr_mask) | evt_i;
        if (en_we_i) begin
            bank_d.enable = en_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status_o = bank_q.status;
    assign enable_o = bank_q.enable;
    assign pend_o   = |(bank_q.status & bank_q.enable);

endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper #(
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic glb_i,
    input  logic pulse_mode_i,
    output logic active_o
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          active;
    } shp_t;

    shp_t shp_d, shp_q;
    logic rise;

    always_comb begin
        shp_d      = shp_q;
        // prev follows the ungated OR, so pending bits never replay on enable.
        shp_d.prev = raw_i;
        rise       = raw_i & ~shp_q.prev & glb_i & pulse_mode_i;
        if (!pulse_mode_i) begin
            shp_d.cnt = '0;
        end else if (rise) begin
            shp_d.cnt = CW'(PULSE_CYC);
        end else if (shp_q.cnt != '0) begin
            shp_d.cnt = shp_q.cnt - CW'(1);
        end
        shp_d.active = glb_i & (pulse_mode_i ? (shp_d.cnt != '0) : raw_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shp_q <= '0;
        end else begin
            shp_q <= shp_d;
        end
    end

    assign active_o = shp_q.active;

endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen
    import irq_pkg::*;
#(
    parameter int          USB_W    = 8,
    parameter int          DMA_W    = 4,
    parameter int unsigned CLK_PS   = 16667,
    parameter int unsigned PULSE_PS = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [USB_W-1:0] usb_evt_i,
    input  logic [DMA_W-1:0] dma_evt_i,
    input  logic             usb_clr_we_i,
    input  logic [USB_W-1:0] usb_clr_data_i,
    input  logic             usb_en_we_i,
    input  logic [USB_W-1:0] usb_en_data_i,
    input  logic             dma_clr_we_i,
    input  logic [DMA_W-1:0] dma_clr_data_i,
    input  logic             dma_en_we_i,
    input  logic [DMA_W-1:0] dma_en_data_i,
    input  logic             cfg_we_i,
    input  logic             cfg_pol_high_i,
    input  logic             cfg_pulse_mode_i,
    input  logic             glb_we_i,
    input  logic             glb_en_i,
    output logic             irq_pin_o,
    output logic [USB_W-1:0] usb_status_o,
    output logic [USB_W-1:0] usb_enable_o,
    output logic [DMA_W-1:0] dma_status_o,
    output logic [DMA_W-1:0] dma_enable_o,
    output logic             cfg_pol_high_o,
    output logic             cfg_pulse_mode_o,
    output logic             glb_en_o
);

    localparam int unsigned PULSE_CYC = pulse_cycles(PULSE_PS, CLK_PS);

    typedef struct packed {
        irq_cfg_t cfg;
        logic     glb;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic usb_pend, dma_pend, raw_any, active;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we_i) begin
            ctl_d.cfg.pol_high   = cfg_pol_high_i;
            ctl_d.cfg.pulse_mode = cfg_pulse_mode_i;
        end
        if (glb_we_i) begin
            ctl_d.glb = glb_en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    irq_latch_bank #(.W(USB_W)) usb_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (usb_evt_i),
        .clr_we_i   (usb_clr_we_i),
        .clr_data_i (usb_clr_data_i),
        .en_we_i    (usb_en_we_i),
        .en_data_i  (usb_en_data_i),
        .status_o   (usb_status_o),
        .enable_o   (usb_enable_o),
        .pend_o     (usb_pend)
    );

    irq_latch_bank #(.W(DMA_W)) dma_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (dma_evt_i),
        .clr_we_i   (dma_clr_we_i),
        .clr_data_i (dma_clr_data_i),
        .en_we_i    (dma_en_we_i),
        .en_data_i  (dma_en_data_i),
        .status_o   (dma_status_o),
        .enable_o   (dma_enable_o),
        .pend_o     (dma_pend)
    );

    assign raw_any = usb_pend | dma_pend;

    irq_pin_shaper #(.PULSE_CYC(PULSE_CYC)) shaper_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_i        (raw_any),
        .glb_i        (ctl_q.glb),
        .pulse_mode_i (ctl_q.cfg.pulse_mode),
        .active_o     (active)
    );

    assign irq_pin_o        = ctl_q.cfg.pol_high ? active : ~active;
    assign cfg_pol_high_o   = ctl_q.cfg.pol_high;
    assign cfg_pulse_mode_o = ctl_q.cfg.pulse_mode;
    assign glb_en_o         = ctl_q.glb;

endmodule

// File: rtl/irq_pin_gen_chk.sv
module irq_pin_gen_chk #(
    parameter int          USB_W     = 8,
    parameter int          DMA_W     = 4,
    parameter int unsigned PULSE_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [USB_W-1:0] usb_evt_i,
    input logic [DMA_W-1:0] dma_evt_i,
    input logic             usb_clr_we_i,
    input logic [USB_W-1:0] usb_clr_data_i,
    input logic             dma_clr_we_i,
    input logic [DMA_W-1:0] dma_clr_data_i,
    input logic             irq_pin_o,
    input logic [USB_W-1:0] usb_status_o,
    input logic [USB_W-1:0] usb_enable_o,
    input logic [DMA_W-1:0] dma_status_o,
    input logic [DMA_W-1:0] dma_enable_o,
    input logic             cfg_pol_high_o,
    input logic             cfg_pulse_mode_o,
    input logic             glb_en_o
);

    logic        act, pend;
    logic [31:0] run_q;

    assign act  = cfg_pol_high_o ? irq_pin_o : ~irq_pin_o;
    assign pend = |(usb_status_o & usb_enable_o) | |(dma_status_o & dma_enable_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (act && cfg_pulse_mode_o) begin
            run_q <= run_q + 32'd1;
        end else begin
            run_q <= '0;
        end
    end

    assert_evt_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((usb_status_o & $past(usb_evt_i)) == $past(usb_evt_i)) &&
                  ((dma_status_o & $past(dma_evt_i)) == $past(dma_evt_i))));

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        usb_clr_we_i |=> ((usb_status_o & $past(usb_clr_data_i) & ~$past(usb_evt_i)) == '0));

    assert_w1c_dma_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_clr_we_i |=> ((dma_status_o & $past(dma_clr_data_i) & ~$past(dma_evt_i)) == '0));

    assert_level_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pulse_mode_o && glb_en_o && pend) |=> act);

    assert_glb_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_o |=> !act);

    assert_level_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pulse_mode_o && !pend) |=> !act);

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= PULSE_CYC);

endmodule

bind irq_pin_gen irq_pin_gen_chk #(
    .USB_W     (USB_W),
    .DMA_W     (DMA_W),
    .PULSE_CYC (PULSE_CYC)
) chk_i (.*);

// File: tb/irq_pin_gen_tb.sv
module irq_pin_gen_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          USB_W      = 8;
    localparam int          DMA_W      = 4;
    localparam int unsigned CLK_PS     = 16667;
    localparam int          EXP_PULSE  = (60000 + CLK_PS - 1) / CLK_PS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [USB_W-1:0] usb_evt = '0, usb_clr_data = '0, usb_en_data = '0;
    logic [DMA_W-1:0] dma_evt = '0, dma_clr_data = '0, dma_en_data = '0;
    logic usb_clr_we = 0, usb_en_we = 0, dma_clr_we = 0, dma_en_we = 0;
    logic cfg_we = 0, cfg_pol = 0, cfg_pulse = 0, glb_we = 0, glb_en = 0;
    logic             irq_pin, pol_o, pulse_o, glb_o;
    logic [USB_W-1:0] usb_status, usb_enable;
    logic [DMA_W-1:0] dma_status, dma_enable;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  pol_model = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_gen #(.USB_W(USB_W), .DMA_W(DMA_W), .CLK_PS(CLK_PS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .usb_evt_i(usb_evt), .dma_evt_i(dma_evt),
        .usb_clr_we_i(usb_clr_we), .usb_clr_data_i(usb_clr_data),
        .usb_en_we_i(usb_en_we), .usb_en_data_i(usb_en_data),
        .dma_clr_we_i(dma_clr_we), .dma_clr_data_i(dma_clr_data),
        .dma_en_we_i(dma_en_we), .dma_en_data_i(dma_en_data),
        .cfg_we_i(cfg_we), .cfg_pol_high_i(cfg_pol), .cfg_pulse_mode_i(cfg_pulse),
        .glb_we_i(glb_we), .glb_en_i(glb_en),
        .irq_pin_o(irq_pin), .usb_status_o(usb_status), .usb_enable_o(usb_enable),
        .dma_status_o(dma_status), .dma_enable_o(dma_enable),
        .cfg_pol_high_o(pol_o), .cfg_pulse_mode_o(pulse_o), .glb_en_o(glb_o)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic pin_of(input bit active);
        return pol_model ? active : ~active;
    endfunction

    task automatic usb_event(input logic [USB_W-1:0] m);
        usb_evt = m; tick(); usb_evt = '0;
    endtask
    task automatic dma_event(input logic [DMA_W-1:0] m);
        dma_evt = m; tick(); dma_evt = '0;
    endtask
    task automatic usb_clear(input logic [USB_W-1:0] m);
        usb_clr_we = 1; usb_clr_data = m; tick(); usb_clr_we = 0; usb_clr_data = '0;
    endtask
    task automatic dma_clear(input logic [DMA_W-1:0] m);
        dma_clr_we = 1; dma_clr_data = m; tick(); dma_clr_we = 0; dma_clr_data = '0;
    endtask
    task automatic usb_enable_wr(input logic [USB_W-1:0] m);
        usb_en_we = 1; usb_en_data = m; tick(); usb_en_we = 0;
    endtask
    task automatic dma_enable_wr(input logic [DMA_W-1:0] m);
        dma_en_we = 1; dma_en_data = m; tick(); dma_en_we = 0;
    endtask
    task automatic set_cfg(input bit pol, input bit pulse);
        cfg_we = 1; cfg_pol = pol; cfg_pulse = pulse; tick(); cfg_we = 0;
        pol_model = pol;
    endtask
    task automatic set_glb(input bit v);
        glb_we = 1; glb_en = v; tick(); glb_we = 0;
    endtask

    // Counts active samples over n cycles; first_o is the first active sample index.
    task automatic count_active(input int n, output int cnt, output int first_o);
        cnt = 0; first_o = -1;
        for (int i = 1; i <= n; i++) begin
            if (irq_pin === pin_of(1'b1)) begin
                cnt++;
                if (first_o < 0) first_o = i;
            end
            tick();
        end
    endtask

    task automatic t_reset;
        chk("R4", "pin", irq_pin, 1'b1);
        chk("R4", "usb status", usb_status, 0);
        chk("R4", "dma status", dma_status, 0);
        chk("R4", "enables", {usb_enable, dma_enable}, 0);
        chk("R4", "cfg/glb", {pol_o, pulse_o, glb_o}, 0);
    endtask

    task automatic t_latch;
        usb_event(8'h04);
        chk("R1", "usb bit latched w/o enables", usb_status, 8'h04);
        dma_event(4'h2);
        chk("R1", "dma bit latched w/o enables", dma_status, 4'h2);
        usb_event(8'h01);
        chk("R1", "usb bits accumulate", usb_status, 8'h05);
        tick();
        chk("R6", "pin idle with nothing enabled", irq_pin, pin_of(1'b0));
    endtask

    task automatic t_clear;
        usb_clear(8'h01);
        chk("R2", "w1c clears only ones", usb_status, 8'h04);
        usb_clear(8'h00);
        chk("R2", "zero write keeps bits", usb_status, 8'h04);
        dma_clear(4'h2);
        chk("R2", "dma w1c", dma_status, 4'h0);
        usb_evt = 8'h08; usb_clr_we = 1; usb_clr_data = 8'h0C; tick();
        usb_evt = '0; usb_clr_we = 0; usb_clr_data = '0;
        chk("R3", "event beats clear", usb_status, 8'h08);
        usb_clear(8'hFF);
        chk("R2", "clear all", usb_status, 8'h00);
    endtask

    task automatic t_level;
        usb_enable_wr(8'h01);
        set_glb(1);
        usb_event(8'h02);
        tick();
        chk("R6", "disabled bit ignored", irq_pin, pin_of(1'b0));
        usb_event(8'h01);
        chk("R5", "pin not yet active", irq_pin, pin_of(1'b0));
        tick();
        chk("R5", "pin active usb", irq_pin, pin_of(1'b1));
        tick(5);
        chk("R7", "pin held while pending", irq_pin, pin_of(1'b1));
        usb_clear(8'h01);
        chk("R7", "pin active until registered", irq_pin, pin_of(1'b1));
        tick();
        chk("R7", "pin released after clear", irq_pin, pin_of(1'b0));
        dma_enable_wr(4'h1);
        dma_event(4'h1);
        tick();
        chk("R5", "pin active dma", irq_pin, pin_of(1'b1));
        dma_clear(4'h1);
        tick();
        chk("R7", "pin released dma", irq_pin, pin_of(1'b0));
        dma_enable_wr(4'h0);
        usb_clear(8'hFF);
    endtask

    task automatic t_glb;
        set_glb(0);
        usb_event(8'h01);
        tick(3);
        chk("R6", "global off keeps pin idle", irq_pin, pin_of(1'b0));
        set_glb(1);
        chk("R6", "one cycle after enable", irq_pin, pin_of(1'b0));
        tick();
        chk("R6", "pending asserts on enable", irq_pin, pin_of(1'b1));
        set_glb(0);
        tick();
        chk("R6", "global off deasserts", irq_pin, pin_of(1'b0));
        usb_clear(8'h01);
        set_glb(1);
    endtask

    task automatic t_pulse;
        int c, f;
        set_cfg(0, 1);
        usb_event(8'h01);
        count_active(EXP_PULSE + 6, c, f);
        chk("R8", "pulse width", c, EXP_PULSE);
        chk("R8", "pulse start", f, 2);
        chk("R8", "bit still pending", usb_status, 8'h01);
        usb_event(8'h01);
        count_active(8, c, f);
        chk("R8", "no pulse while pending", c, 0);
        usb_clear(8'h01);
        usb_event(8'h01);
        count_active(EXP_PULSE + 6, c, f);
        chk("R8", "second pulse width", c, EXP_PULSE);
        usb_clear(8'h01);
    endtask

    task automatic t_pulse_pending;
        int c, f;
        set_glb(0);
        usb_event(8'h01);
        tick(2);
        set_glb(1);
        count_active(10, c, f);
        chk("R9", "no replay of pending", c, 0);
        usb_clear(8'h01);
        tick();
        set_cfg(0, 0);
    endtask

    task automatic t_pol;
        set_cfg(1, 0);
        chk("R10", "idle high-polarity", irq_pin, 1'b0);
        usb_event(8'h01);
        tick();
        chk("R10", "active high-polarity", irq_pin, 1'b1);
        usb_clear(8'h01);
        tick();
        chk("R10", "released high-polarity", irq_pin, 1'b0);
        set_cfg(0, 0);
        chk("R10", "back to active-low idle", irq_pin, 1'b1);
    endtask

    bit finished = 0;

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_latch();
        t_clear();
        t_level();
        t_glb();
        t_pulse();
        t_pulse_pending();
        t_pol();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule